// File: doc/BRIEF.md
# Branch history rolling buffer

The block keeps the most recent branch-history words in a small ring of 64-bit slots. A record strobe stores one word in the slot under the write pointer and then moves the pointer forward, so the newest word always overwrites the oldest. The number of slots is a parameter.

Software has two operations. It can wipe the whole ring, or it can read one word by age. Age zero is the most recent record, age one is the record before it, and so on. The read result is registered and valid one cycle after the request.

Both software operations pass through a permission gate. A hypervisor facility bit must be set, and in user mode a separate access-enable bit must also be set. A refused operation raises a fault pulse with a code that says which check refused it. A refused operation leaves the ring untouched.

Top module: `branch_hist_buf`

## Requirements
- R1: After reset, all slots hold zero and the write pointer is slot 0. `rd_valid`, `rd_data`, `fault` and `fault_code` are all zero.
- R2: Each cycle with `rec_valid` high and no permitted clear, `rec_data` is stored in the slot under the write pointer. The pointer then advances by one and wraps from DEPTH-1 back to 0.
- R3: A permitted, in-range read of age n returns the slot (pointer − (n+1)) mod DEPTH. After more than DEPTH records, age 0 is the newest word and age DEPTH-1 is the oldest word still held.
- R4: A permitted clear (`clr_req`) sets every slot to zero and returns the write pointer to slot 0.
- R5: When a permitted clear and a record fall in the same cycle, the clear wins. The record is dropped and the pointer is 0 afterwards.
- R6: A read whose age is DEPTH or larger returns zero and raises no fault.
- R7: While `pm_alert` is high, every read returns zero and raises no fault.
- R8: With `hyp_en` low, any clear or read faults with `fault_code` = 2'b01. This check takes priority over the user-mode check.
- R9: With `hyp_en` high, `user_mode` high and `acc_en` low, any clear or read faults with `fault_code` = 2'b10. In supervisor mode (`user_mode` low), `acc_en` has no effect.
- R10: A refused clear leaves every slot and the pointer unchanged, and a refused read returns zero. A record in the same cycle as a refused clear still takes place.
- R11: `rd_valid`, `rd_data`, `fault` and `fault_code` are registered. They show the result of a request in the cycle after it and return to zero when there is no request.
- R12: A read issued in the same cycle as a record or a permitted clear returns the contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Store `rec_data` at the write pointer |
| rec_data | input | W (64) | History word to store |
| clr_req | input | 1 | Request to zero the whole ring |
| rd_req | input | 1 | Request to read one entry |
| rd_age | input | IDX_W (10) | Age of the entry to read, 0 = newest |
| user_mode | input | 1 | 1 = user (problem) state, 0 = supervisor |
| acc_en | input | 1 | User-mode access enable |
| hyp_en | input | 1 | Hypervisor facility enable for the buffer |
| pm_alert | input | 1 | Performance-monitor alert enable; forces reads to zero |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_req` |
| rd_data | output | W (64) | Read result |
| fault | output | 1 | Facility-unavailable pulse for a refused clear or read |
| fault_code | output | 2 | 2'b01 = hypervisor bit clear, 2'b10 = user access disabled |

## Verification
A record and a clear can land on the same clock edge, and both change the write pointer and the slot contents. The bench drives both strobes in one cycle, once with the clear permitted and once with it refused. It then writes DEPTH fresh words and reads every age. The permitted case must show only the fresh words, in age order, starting from slot 0. The refused case must show the colliding record as the newest word on top of the old history. A read in the same cycle as a record or a clear is also driven, and it must return the contents from before the edge.

// File: rtl/bhb_pkg.sv
package bhb_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_HYP  = 2'b01,
        FC_USR  = 2'b10
    } fcode_e;

    localparam int unsigned DEF_W     = 64;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_IDX_W = 10;

endpackage

// File: rtl/bhb_gate.sv
// Permission gate for the software operations (clear, read).
module bhb_gate
    import bhb_pkg::*;
(
    input  logic   user_mode,
    input  logic   acc_en,
    input  logic   hyp_en,
    output fcode_e code
);

    always_comb begin
        code = FC_NONE;
        if (!hyp_en) begin
            code = FC_HYP;
        end else if (user_mode && !acc_en) begin
            code = FC_USR;
        end
    end

endmodule

// File: rtl/bhb_wptr.sv
// Write pointer: advances on record, returns to zero on clear.
module bhb_wptr #(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    input  logic             clr_do,
    output logic [PTR_W-1:0] wptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_do) begin
            st_d.ptr = '0;
        end else if (rec_valid) begin
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr = st_q.ptr;

endmodule

// File: rtl/bhb_store.sv
// Slot storage with age-to-slot mapping on the read side.
module bhb_store #(
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned W     = 64,
    parameter  int unsigned IDX_W = 10,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             clr,
    input  logic [PTR_W-1:0] wptr,
    input  logic [IDX_W-1:0] age,
    output logic [W-1:0]     rd_word,
    output logic             rd_hit
);

    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [W-1:0]     mem_d [DEPTH];
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] slot;

    // Next-state for the slots: a clear overrides a record.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = '0;
            end
        end else if (wr_en) begin
            mem_d[wptr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    // Age n lives one slot behind the pointer, n further back.
    generate
        if (POW2) begin : g_pow2
            assign slot = wptr - age[PTR_W-1:0] - PTR_W'(1);
        end else begin : g_mod
            logic [PTR_W:0] sum;
            always_comb begin
                sum = {1'b0, wptr} + (PTR_W+1)'(DEPTH - 1) - {1'b0, age[PTR_W-1:0]};
                if (sum >= (PTR_W+1)'(DEPTH)) begin
                    sum = sum - (PTR_W+1)'(DEPTH);
                end
            end
            assign slot = sum[PTR_W-1:0];
        end
    endgenerate

    assign rd_hit  = ({1'b0, age} < (IDX_W+1)'(DEPTH));
    assign rd_word = rd_hit ? mem_q[slot] : '0;

endmodule

// File: rtl/bhb_rdport.sv
// Registered result port: read data, valid and fault report.
module bhb_rdport
    import bhb_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_req,
    input  logic         clr_req,
    input  fcode_e       code,
    input  logic         alert,
    input  logic         hit,
    input  logic [W-1:0] word,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    output logic         fault,
    output logic [1:0]   fault_code
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
        logic         fault;
        logic [1:0]   code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.valid = rd_req;
        if ((rd_req || clr_req) && (code != FC_NONE)) begin
            st_d.fault = 1'b1;
            st_d.code  = code;
        end
        if (rd_req && (code == FC_NONE) && !alert && hit) begin
            st_d.data = word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid   = st_q.valid;
    assign rd_data    = st_q.data;
    assign fault      = st_q.fault;
    assign fault_code = st_q.code;

endmodule

// File: rtl/branch_hist_buf.sv
module branch_hist_buf
    import bhb_pkg::*;
#(
    parameter  int unsigned W     = DEF_W,
    parameter  int unsigned DEPTH = DEF_DEPTH,
    parameter  int unsigned IDX_W = DEF_IDX_W,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    input  logic [W-1:0]     rec_data,
    input  logic             clr_req,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_age,
    input  logic             user_mode,
    input  logic             acc_en,
    input  logic             hyp_en,
    input  logic             pm_alert,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic             fault,
    output logic [1:0]       fault_code
);

    fcode_e           code;
    logic             clr_do;
    logic [PTR_W-1:0] wptr;
    logic [W-1:0]     word;
    logic             hit;

    bhb_gate u_gate (
        .user_mode (user_mode),
        .acc_en    (acc_en),
        .hyp_en    (hyp_en),
        .code      (code)
    );

    assign clr_do = clr_req && (code == FC_NONE);

    bhb_wptr #(.DEPTH(DEPTH)) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .clr_do    (clr_do),
        .wptr      (wptr)
    );

    bhb_store #(.DEPTH(DEPTH), .W(W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rec_valid),
        .wr_data (rec_data),
        .clr     (clr_do),
        .wptr    (wptr),
        .age     (rd_age),
        .rd_word (word),
        .rd_hit  (hit)
    );

    bhb_rdport #(.W(W)) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .clr_req    (clr_req),
        .code       (code),
        .alert      (pm_alert),
        .hit        (hit),
        .word       (word),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .fault      (fault),
        .fault_code (fault_code)
    );

endmodule

// File: rtl/bhb_checker.sv
module bhb_checker #(
    parameter  int unsigned W     = 64,
    parameter  int unsigned DEPTH = 8,
    parameter  int unsigned IDX_W = 10,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_valid,
    input logic             clr_req,
    input logic             rd_req,
    input logic [IDX_W-1:0] rd_age,
    input logic             user_mode,
    input logic             acc_en,
    input logic             hyp_en,
    input logic             pm_alert,
    input logic             rd_valid,
    input logic [W-1:0]     rd_data,
    input logic             fault,
    input logic [1:0]       fault_code,
    input logic [PTR_W-1:0] wptr
);

    logic perm_ok;
    assign perm_ok = hyp_en && (!user_mode || acc_en);

    // R2: pointer steps by one with wrap on an uncontested record
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !(clr_req && perm_ok)) |=>
        (wptr == (($past(wptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(wptr) + PTR_W'(1))));

    // R5: permitted clear beats a record in the same cycle
    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && perm_ok) |=> (wptr == '0));

    // R6: out-of-range age reads as zero
    p_range_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ({1'b0, rd_age} >= (IDX_W+1)'(DEPTH))) |=> (rd_data == '0));

    // R7: alert flag forces zero
    p_alert_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && pm_alert) |=> (rd_data == '0));

    // R8: hypervisor bit clear refuses the operation
    p_hyp_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || clr_req) && !hyp_en) |=> (fault && fault_code == 2'b01 && rd_data == '0));

    // R9: user mode without access enable refuses the operation
    p_usr_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_req || clr_req) && hyp_en && user_mode && !acc_en) |=> (fault && fault_code == 2'b10));

    // R10: a refused clear leaves the pointer alone unless a record moves it
    p_refused_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !perm_ok && !rec_valid) |=> $stable(wptr));

    // R11: valid follows the request by one cycle; no fault without an operation
    p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !clr_req) |=> (!rd_valid && !fault && fault_code == 2'b00));

endmodule

bind branch_hist_buf bhb_checker #(.W(W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_valid  (rec_valid),
    .clr_req    (clr_req),
    .rd_req     (rd_req),
    .rd_age     (rd_age),
    .user_mode  (user_mode),
    .acc_en     (acc_en),
    .hyp_en     (hyp_en),
    .pm_alert   (pm_alert),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fault      (fault),
    .fault_code (fault_code),
    .wptr       (wptr)
);

// File: tb/branch_hist_buf_test.sv
module branch_hist_buf_test;

    localparam int unsigned W     = 64;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rec_valid = 1'b0;
    logic [W-1:0]     rec_data = '0;
    logic             clr_req = 1'b0;
    logic             rd_req = 1'b0;
    logic [IDX_W-1:0] rd_age = '0;
    logic             user_mode = 1'b0;
    logic             acc_en = 1'b1;
    logic             hyp_en = 1'b1;
    logic             pm_alert = 1'b0;
    logic             rd_valid;
    logic [W-1:0]     rd_data;
    logic             fault;
    logic [1:0]       fault_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    branch_hist_buf #(.W(W), .DEPTH(DEPTH), .IDX_W(IDX_W)) uut (
        .clk (clk), .rst_n (rst_n), .rec_valid (rec_valid), .rec_data (rec_data),
        .clr_req (clr_req), .rd_req (rd_req), .rd_age (rd_age),
        .user_mode (user_mode), .acc_en (acc_en), .hyp_en (hyp_en), .pm_alert (pm_alert),
        .rd_valid (rd_valid), .rd_data (rd_data), .fault (fault), .fault_code (fault_code)
    );

    // Reference history: every accepted record in order, cleared by a permitted clear.
    logic [W-1:0] hist [256];
    int           cnt = 0;

    function automatic logic [W-1:0] model_at(int n);
        if (n >= DEPTH || n >= cnt) return '0;
        return hist[cnt - 1 - n];
    endfunction

    function automatic logic [1:0] exp_code(logic u, logic a, logic h);
        if (!h) return 2'b01;
        if (u && !a) return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock of stimulus; outputs are sampled at the following falling edge.
    task automatic step(logic rec, logic [W-1:0] d, logic clr, logic rd, int age);
        rec_valid = rec;
        rec_data  = d;
        clr_req   = clr;
        rd_req    = rd;
        rd_age    = IDX_W'(age);
        @(negedge clk);
        rec_valid = 1'b0;
        clr_req   = 1'b0;
        rd_req    = 1'b0;
    endtask

    task automatic record(logic [W-1:0] d);
        step(1'b1, d, 1'b0, 1'b0, 0);
        hist[cnt] = d;
        cnt++;
    endtask

    task automatic read_chk(string req, int age, logic [W-1:0] exp);
        step(1'b0, '0, 1'b0, 1'b1, age);
        chk(req, rd_data, exp);
        chk({req, " valid"}, W'(rd_valid), W'(1));
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < DEPTH; k++) begin
            read_chk(req, k, model_at(k));
        end
    endtask

    typedef struct packed {
        logic [7:0] age;
        logic       usr;
        logic       acc;
        logic       hyp;
        logic       alert;
    } rvec_t;

    localparam rvec_t RV [12] = '{
        '{8'd0,   1'b0, 1'b1, 1'b1, 1'b0},  // R3 newest
        '{8'd1,   1'b0, 1'b1, 1'b1, 1'b0},  // R3
        '{8'd7,   1'b0, 1'b1, 1'b1, 1'b0},  // R3 oldest after wrap
        '{8'd8,   1'b0, 1'b1, 1'b1, 1'b0},  // R6 boundary
        '{8'd200, 1'b0, 1'b1, 1'b1, 1'b0},  // R6
        '{8'd3,   1'b0, 1'b1, 1'b1, 1'b1},  // R7
        '{8'd0,   1'b0, 1'b1, 1'b0, 1'b0},  // R8
        '{8'd2,   1'b1, 1'b0, 1'b1, 1'b0},  // R9 user refused
        '{8'd4,   1'b1, 1'b1, 1'b1, 1'b0},  // R9 user allowed
        '{8'd2,   1'b1, 1'b0, 1'b0, 1'b0},  // R8 priority over R9
        '{8'd5,   1'b0, 1'b0, 1'b1, 1'b0},  // R9 supervisor ignores acc_en
        '{8'd6,   1'b1, 1'b1, 1'b1, 1'b1}   // R7 in user mode
    };

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rd_valid", W'(rd_valid), W'(0));
        chk("R1 rd_data", rd_data, '0);
        chk("R1 fault", W'({fault, fault_code}), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R1 slots zero");

        // R2/R3: fill past one wrap
        for (int i = 0; i < 11; i++) record(64'hA5A5_0000_0000_1000 + W'(i));
        read_all("R2 R3 wrap order");

        // Table walk of permission and gating cases
        foreach (RV[v]) begin
            logic [1:0]   ec;
            logic [W-1:0] ed;
            string        tag;
            user_mode = RV[v].usr;
            acc_en    = RV[v].acc;
            hyp_en    = RV[v].hyp;
            pm_alert  = RV[v].alert;
            ec = exp_code(RV[v].usr, RV[v].acc, RV[v].hyp);
            ed = (ec != 2'b00 || RV[v].alert || RV[v].age >= DEPTH) ? '0 : model_at(int'(RV[v].age));
            tag = (ec == 2'b01) ? "R8" : (ec == 2'b10) ? "R9" : RV[v].alert ? "R7" :
                  (RV[v].age >= DEPTH) ? "R6" : "R3";
            step(1'b0, '0, 1'b0, 1'b1, int'(RV[v].age));
            chk({tag, " data"}, rd_data, ed);
            chk({tag, " fault_code"}, W'(fault_code), W'(ec));
            chk({tag, " fault"}, W'(fault), W'(ec != 2'b00));
        end
        user_mode = 1'b0; acc_en = 1'b1; hyp_en = 1'b1; pm_alert = 1'b0;

        // R11: results drop when there is no request
        @(negedge clk);
        chk("R11 valid idle", W'(rd_valid), W'(0));
        chk("R11 data idle", rd_data, '0);

        // R10: refused clears change nothing
        hyp_en = 1'b0;
        step(1'b0, '0, 1'b1, 1'b0, 0);
        chk("R8 clear fault_code", W'({fault, fault_code}), W'(3'b101));
        hyp_en = 1'b1; user_mode = 1'b1; acc_en = 1'b0;
        step(1'b0, '0, 1'b1, 1'b0, 0);
        chk("R9 clear fault_code", W'({fault, fault_code}), W'(3'b110));
        user_mode = 1'b0; acc_en = 1'b1;
        read_all("R10 intact after refused clear");

        // R4: permitted clear
        step(1'b0, '0, 1'b1, 1'b0, 0);
        chk("R4 no fault", W'(fault), W'(0));
        cnt = 0;
        read_all("R4 cleared");
        record(64'h0000_00C0_FFEE_0001);
        read_chk("R4 first after clear", 0, 64'h0000_00C0_FFEE_0001);
        read_chk("R4 rest zero", 1, '0);

        // R5: permitted clear collides with a record
        for (int i = 0; i < 3; i++) record(64'h5555_0000_0000_0000 + W'(i));
        step(1'b1, 64'hDEAD_BEEF_0000_0005, 1'b1, 1'b0, 0);
        cnt = 0;
        read_all("R5 record dropped");
        for (int i = 0; i < DEPTH; i++) record(64'h7000_0000_0000_0000 + W'(i));
        read_all("R5 pointer from zero");

        // R10: refused clear with a record in the same cycle
        hyp_en = 1'b0;
        step(1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0, 0);
        hist[cnt] = 64'h1234_5678_9ABC_DEF0; cnt++;
        chk("R10 fault on collision", W'(fault_code), W'(2'b01));
        hyp_en = 1'b1;
        read_all("R10 record kept, history intact");

        // R12: read alongside a record returns pre-update contents
        step(1'b1, 64'hFACE_0000_0000_0012, 1'b0, 1'b1, 0);
        chk("R12 read with record", rd_data, model_at(0));
        hist[cnt] = 64'hFACE_0000_0000_0012; cnt++;
        read_chk("R12 record landed", 0, 64'hFACE_0000_0000_0012);
        // R12: read alongside a permitted clear
        step(1'b0, '0, 1'b1, 1'b1, 1);
        chk("R12 read with clear", rd_data, model_at(1));
        cnt = 0;
        read_chk("R12 cleared after", 1, '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule